// File: doc/BRIEF.md
# Programmable Panel Timing Generator

This block paces a flat panel. A pixel counter and a line counter run freely from the origin (0,0). The block derives three timing outputs from them: a horizontal sync pulse, a vertical sync pulse and an active-window enable. All three are registered and active high.

Every timing value is held in a byte-wide register file. Values wider than eight bits are split between a low-byte address and a shared high-bits address. Two horizontal-total registers exist, and the `mode_sel` input picks which one bounds the pixel counter. A new total or a new mode is taken up only when a frame wraps, so a line is never cut short.

The block also drives three copies of the pixel clock for line buffers. Each copy has its own polarity bit.

Top module: `panel_timing_gen`

## Requirements
- R1: While `rst` is high, `hsync_o`, `vsync_o` and `de_o` are low, both counters are held at 0 and every register takes its parameter reset value. The polarity bits reset to 0.
- R2: Register map, byte address to bits:
  - 0x10: sync width [7:0].
  - 0x11: horizontal start [7:0].
  - 0x12: horizontal end [7:0].
  - 0x13: bit0 is sync width [8], bit1 is horizontal start [8], bits6:4 are horizontal end [10:8].
  - 0x14: total for mode 0 [7:0].
  - 0x15: total for mode 1 [7:0].
  - 0x16: bits2:0 are mode-0 total [10:8], bits6:4 are mode-1 total [10:8].
  - 0x17: vertical sync width.
  - 0x18: vertical start.
  - 0x19: vertical end [7:0].
  - 0x1A: vertical total [7:0].
  - 0x1B: bits1:0 are vertical end [9:8], bits3:2 are vertical total [9:8].

  A write lands on the next clock edge, and a read returns the stored bits.
- R3: The pixel count runs from 0 to the active horizontal total minus 1 and then returns to 0. When the pixel count wraps, the line count advances. The line count runs from 0 to the active vertical total minus 1.
- R4: `hsync_o` is high one clock after each cycle whose pixel count is below the horizontal sync width. A width of 0 gives no pulse.
- R5: `vsync_o` is high one clock after each cycle whose line count is below the vertical sync width.
- R6: `de_o` is high one clock after each cycle in which start <= count < end holds for both axes. When start >= end on an axis, `de_o` never goes high.
- R7: The active totals are loaded only when a frame wraps (last pixel of the last line). The horizontal total is loaded from the register that `mode_sel` selects at that moment. A change of `mode_sel` or of a total register mid-frame changes nothing before then.
- R8: Register 0xF7 bits 0, 1 and 2 control line-buffer clocks `lbclk_o[0]`, `[1]` and `[2]`. A 0 passes `clk` through and a 1 inverts it. Bits 7:3 read 0.
- R9: Unused bits of mapped addresses read 0, and writes to them are dropped. Unmapped addresses read 0 and writing them changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | Selects the horizontal total register (0 or 1) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Active-window enable |
| lbclk_o | output | 3 | Polarity-controlled line-buffer clocks |

## Verification
The hardest case to reach from the ports is a mid-frame change of the mode input or of a total register, because its effect must stay invisible until the frame wraps. The bench aligns itself to a vertical sync rising edge and waits several lines. It then flips `mode_sel` or rewrites a total, and measures the spacing between horizontal sync edges. The spacing must stay unchanged inside the current frame and change only in the next one. A cycle-level model inside the bench follows the counters, the frame-boundary latch and every register write, and compares all three timing outputs on every clock.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;
    localparam int HCNT_W  = 11;
    localparam int VCNT_W  = 10;
    localparam int HSW_W   = 9;
    localparam int HST_W   = 9;
    localparam int VSW_W   = 8;
    localparam int VST_W   = 8;
    localparam int LBCLK_N = 3;
    localparam int CMP_W   = HCNT_W + 1;

    typedef logic [CMP_W-1:0] cmp_t;

    // byte addresses; the high-bit packing is fixed by the map
    localparam logic [ADDR_W-1:0] A_HSW_LO  = 8'h10;
    localparam logic [ADDR_W-1:0] A_HST_LO  = 8'h11;
    localparam logic [ADDR_W-1:0] A_HEND_LO = 8'h12;
    localparam logic [ADDR_W-1:0] A_HHI     = 8'h13;
    localparam logic [ADDR_W-1:0] A_HT0_LO  = 8'h14;
    localparam logic [ADDR_W-1:0] A_HT1_LO  = 8'h15;
    localparam logic [ADDR_W-1:0] A_HTHI    = 8'h16;
    localparam logic [ADDR_W-1:0] A_VSW     = 8'h17;
    localparam logic [ADDR_W-1:0] A_VST     = 8'h18;
    localparam logic [ADDR_W-1:0] A_VEND_LO = 8'h19;
    localparam logic [ADDR_W-1:0] A_VT_LO   = 8'h1A;
    localparam logic [ADDR_W-1:0] A_VHI     = 8'h1B;
    localparam logic [ADDR_W-1:0] A_POL     = 8'hF7;

    typedef struct packed {
        logic [HSW_W-1:0]  hsw;
        logic [HST_W-1:0]  hstart;
        logic [HCNT_W-1:0] hend;
        logic [HCNT_W-1:0] htot0;
        logic [HCNT_W-1:0] htot1;
        logic [VSW_W-1:0]  vsw;
        logic [VST_W-1:0]  vstart;
        logic [VCNT_W-1:0] vend;
        logic [VCNT_W-1:0] vtot;
    } ptg_cfg_t;

    // last position of a count bounded by tot (tot of 0 or 1 wraps every cycle)
    function automatic logic is_last(input cmp_t cnt, input cmp_t tot);
        return (cnt + cmp_t'(1)) >= tot;
    endfunction

    function automatic logic in_span(input cmp_t cnt, input cmp_t lo, input cmp_t hi);
        return (cnt >= lo) && (cnt < hi);
    endfunction

endpackage

// File: rtl/ptg_regfile.sv
module ptg_regfile
    import ptg_pkg::*;
#(
    parameter logic [HSW_W-1:0]  HSW_RST  = 9'h010,
    parameter logic [HST_W-1:0]  HST_RST  = 9'h020,
    parameter logic [HCNT_W-1:0] HEND_RST = 11'h200,
    parameter logic [HCNT_W-1:0] HT0_RST  = 11'h326,
    parameter logic [HCNT_W-1:0] HT1_RST  = 11'h29D,
    parameter logic [VSW_W-1:0]  VSW_RST  = 8'h02,
    parameter logic [VST_W-1:0]  VST_RST  = 8'h05,
    parameter logic [VCNT_W-1:0] VEND_RST = 10'h0F0,
    parameter logic [VCNT_W-1:0] VT_RST   = 10'h0F4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output ptg_cfg_t           cfg,
    output logic [LBCLK_N-1:0] pol
);

    ptg_cfg_t           cfg_q;
    logic [LBCLK_N-1:0] pol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.hsw    <= HSW_RST;
            cfg_q.hstart <= HST_RST;
            cfg_q.hend   <= HEND_RST;
            cfg_q.htot0  <= HT0_RST;
            cfg_q.htot1  <= HT1_RST;
            cfg_q.vsw    <= VSW_RST;
            cfg_q.vstart <= VST_RST;
            cfg_q.vend   <= VEND_RST;
            cfg_q.vtot   <= VT_RST;
            pol_q        <= '0;
        end else if (we) begin
            case (addr)
                A_HSW_LO:  cfg_q.hsw[7:0]    <= wdata;
                A_HST_LO:  cfg_q.hstart[7:0] <= wdata;
                A_HEND_LO: cfg_q.hend[7:0]   <= wdata;
                A_HHI: begin
                    cfg_q.hsw[8]            <= wdata[0];
                    cfg_q.hstart[8]         <= wdata[1];
                    cfg_q.hend[HCNT_W-1:8]  <= wdata[6:4];
                end
                A_HT0_LO:  cfg_q.htot0[7:0]  <= wdata;
                A_HT1_LO:  cfg_q.htot1[7:0]  <= wdata;
                A_HTHI: begin
                    cfg_q.htot0[HCNT_W-1:8] <= wdata[2:0];
                    cfg_q.htot1[HCNT_W-1:8] <= wdata[6:4];
                end
                A_VSW:     cfg_q.vsw         <= wdata;
                A_VST:     cfg_q.vstart      <= wdata;
                A_VEND_LO: cfg_q.vend[7:0]   <= wdata;
                A_VT_LO:   cfg_q.vtot[7:0]   <= wdata;
                A_VHI: begin
                    cfg_q.vend[VCNT_W-1:8]  <= wdata[1:0];
                    cfg_q.vtot[VCNT_W-1:8]  <= wdata[3:2];
                end
                A_POL:     pol_q             <= wdata[LBCLK_N-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            A_HSW_LO:  rdata = cfg_q.hsw[7:0];
            A_HST_LO:  rdata = cfg_q.hstart[7:0];
            A_HEND_LO: rdata = cfg_q.hend[7:0];
            A_HHI:     rdata = {1'b0, cfg_q.hend[HCNT_W-1:8], 2'b00, cfg_q.hstart[8], cfg_q.hsw[8]};
            A_HT0_LO:  rdata = cfg_q.htot0[7:0];
            A_HT1_LO:  rdata = cfg_q.htot1[7:0];
            A_HTHI:    rdata = {1'b0, cfg_q.htot1[HCNT_W-1:8], 1'b0, cfg_q.htot0[HCNT_W-1:8]};
            A_VSW:     rdata = cfg_q.vsw;
            A_VST:     rdata = cfg_q.vstart;
            A_VEND_LO: rdata = cfg_q.vend[7:0];
            A_VT_LO:   rdata = cfg_q.vtot[7:0];
            A_VHI:     rdata = {4'b0000, cfg_q.vtot[VCNT_W-1:8], cfg_q.vend[VCNT_W-1:8]};
            A_POL:     rdata = {{(DATA_W-LBCLK_N){1'b0}}, pol_q};
            default:   rdata = '0;
        endcase
    end

    assign cfg = cfg_q;
    assign pol = pol_q;

    // R2: a low-byte write is visible in the field one edge later
    a_r2_low_byte_write: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_HSW_LO) |=> (cfg_q.hsw[7:0] == $past(wdata)));

    // R8: polarity bits follow a write to their address
    a_r8_pol_write: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_POL) |=> (pol_q == $past(wdata[LBCLK_N-1:0])));

    // R9: unmapped writes leave every field alone
    a_r9_unmapped_quiet: assert property (@(posedge clk) disable iff (rst)
        (we && addr == 8'h20) |=> ($stable(cfg_q) && $stable(pol_q)));

endmodule

// File: rtl/ptg_counters.sv
module ptg_counters
    import ptg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_sel,
    input  logic [HCNT_W-1:0] htot0,
    input  logic [HCNT_W-1:0] htot1,
    input  logic [VCNT_W-1:0] vtot,
    output logic [HCNT_W-1:0] hcnt,
    output logic [VCNT_W-1:0] vcnt
);

    logic [HCNT_W-1:0] hcnt_q, htot_q;
    logic [VCNT_W-1:0] vcnt_q, vtot_q;
    logic              line_last, frame_last;
    logic [HCNT_W-1:0] htot_sel;

    assign htot_sel   = mode_sel ? htot1 : htot0;
    assign line_last  = is_last(cmp_t'(hcnt_q), cmp_t'(htot_q));
    assign frame_last = line_last && is_last(cmp_t'(vcnt_q), cmp_t'(vtot_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt_q <= '0;
            vcnt_q <= '0;
            htot_q <= htot_sel;
            vtot_q <= vtot;
        end else begin
            hcnt_q <= line_last ? '0 : hcnt_q + 1'b1;
            if (frame_last) begin
                vcnt_q <= '0;
                htot_q <= htot_sel;
                vtot_q <= vtot;
            end else if (line_last) begin
                vcnt_q <= vcnt_q + 1'b1;
            end
        end
    end

    assign hcnt = hcnt_q;
    assign vcnt = vcnt_q;

    // R3: pixel count stays below the active total
    a_r3_h_in_range: assert property (@(posedge clk) disable iff (rst)
        (htot_q == '0) || (hcnt_q < htot_q));

    // R3: line count steps by one at a line wrap inside a frame
    a_r3_v_step: assert property (@(posedge clk) disable iff (rst)
        (line_last && !frame_last) |=> (vcnt_q == $past(vcnt_q) + 1'b1));

    // R7: active totals hold everywhere except at the frame wrap
    a_r7_total_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_last |=> ($stable(htot_q) && $stable(vtot_q)));

    // R7: a frame wrap returns to the origin
    a_r7_frame_origin: assert property (@(posedge clk) disable iff (rst)
        frame_last |=> (hcnt_q == '0 && vcnt_q == '0));

endmodule

// File: rtl/ptg_sync_out.sv
module ptg_sync_out
    import ptg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [HCNT_W-1:0] hcnt,
    input  logic [VCNT_W-1:0] vcnt,
    input  logic [HSW_W-1:0]  hsw,
    input  logic [HST_W-1:0]  hstart,
    input  logic [HCNT_W-1:0] hend,
    input  logic [VSW_W-1:0]  vsw,
    input  logic [VST_W-1:0]  vstart,
    input  logic [VCNT_W-1:0] vend,
    output logic              hsync,
    output logic              vsync,
    output logic              de
);

    logic hsync_q, vsync_q, de_q;
    logic h_in, v_in;

    assign h_in = in_span(cmp_t'(hcnt), cmp_t'(hstart), cmp_t'(hend));
    assign v_in = in_span(cmp_t'(vcnt), cmp_t'(vstart), cmp_t'(vend));

    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_q <= 1'b0;
            vsync_q <= 1'b0;
            de_q    <= 1'b0;
        end else begin
            hsync_q <= cmp_t'(hcnt) < cmp_t'(hsw);
            vsync_q <= cmp_t'(vcnt) < cmp_t'(vsw);
            de_q    <= h_in && v_in;
        end
    end

    assign hsync = hsync_q;
    assign vsync = vsync_q;
    assign de    = de_q;

    // R4: every line with a nonzero width opens with a sync pulse
    a_r4_hs_at_origin: assert property (@(posedge clk) disable iff (rst)
        (hcnt == '0 && hsw != '0) |=> hsync_q);

    // R6: enable only for a pixel inside the horizontal span
    a_r6_de_inside: assert property (@(posedge clk) disable iff (rst)
        de_q |-> ((cmp_t'($past(hcnt)) >= cmp_t'($past(hstart))) &&
                  (cmp_t'($past(hcnt)) <  cmp_t'($past(hend)))));

    // R5: no vertical pulse past its width
    a_r5_vs_ends: assert property (@(posedge clk) disable iff (rst)
        (cmp_t'(vcnt) >= cmp_t'(vsw)) |=> !vsync_q);

endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
    import ptg_pkg::*;
#(
    parameter logic [HSW_W-1:0]  HSW_RST  = 9'h010,
    parameter logic [HST_W-1:0]  HST_RST  = 9'h020,
    parameter logic [HCNT_W-1:0] HEND_RST = 11'h200,
    parameter logic [HCNT_W-1:0] HT0_RST  = 11'h326,
    parameter logic [HCNT_W-1:0] HT1_RST  = 11'h29D,
    parameter logic [VSW_W-1:0]  VSW_RST  = 8'h02,
    parameter logic [VST_W-1:0]  VST_RST  = 8'h05,
    parameter logic [VCNT_W-1:0] VEND_RST = 10'h0F0,
    parameter logic [VCNT_W-1:0] VT_RST   = 10'h0F4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_sel,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               hsync_o,
    output logic               vsync_o,
    output logic               de_o,
    output logic [LBCLK_N-1:0] lbclk_o
);

    ptg_cfg_t           cfg;
    logic [LBCLK_N-1:0] pol;
    logic [HCNT_W-1:0]  hcnt;
    logic [VCNT_W-1:0]  vcnt;

    ptg_regfile #(
        .HSW_RST(HSW_RST), .HST_RST(HST_RST), .HEND_RST(HEND_RST),
        .HT0_RST(HT0_RST), .HT1_RST(HT1_RST), .VSW_RST(VSW_RST),
        .VST_RST(VST_RST), .VEND_RST(VEND_RST), .VT_RST(VT_RST)
    ) regs_i (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg),
        .pol   (pol)
    );

    ptg_counters cnt_i (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .htot0    (cfg.htot0),
        .htot1    (cfg.htot1),
        .vtot     (cfg.vtot),
        .hcnt     (hcnt),
        .vcnt     (vcnt)
    );

    ptg_sync_out out_i (
        .clk    (clk),
        .rst    (rst),
        .hcnt   (hcnt),
        .vcnt   (vcnt),
        .hsw    (cfg.hsw),
        .hstart (cfg.hstart),
        .hend   (cfg.hend),
        .vsw    (cfg.vsw),
        .vstart (cfg.vstart),
        .vend   (cfg.vend),
        .hsync  (hsync_o),
        .vsync  (vsync_o),
        .de     (de_o)
    );

    for (genvar i = 0; i < LBCLK_N; i++) begin : g_lbclk
        assign lbclk_o[i] = clk ^ pol[i];
    end

    // R1: outputs are quiet in the cycle after a reset edge
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!hsync_o && !vsync_o && !de_o));

endmodule

// File: tb/panel_timing_gen_tb_top.sv
module panel_timing_gen_tb_top;

    localparam int P_HSW = 4, P_HST = 6, P_HEND = 34, P_HT0 = 40, P_HT1 = 30;
    localparam int P_VSW = 2, P_VST = 2, P_VEND = 10, P_VT = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_sel = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       hsync_o, vsync_o, de_o;
    logic [2:0] lbclk_o;

    always #4 clk = ~clk;

    panel_timing_gen #(
        .HSW_RST(9'(P_HSW)), .HST_RST(9'(P_HST)), .HEND_RST(11'(P_HEND)),
        .HT0_RST(11'(P_HT0)), .HT1_RST(11'(P_HT1)), .VSW_RST(8'(P_VSW)),
        .VST_RST(8'(P_VST)), .VEND_RST(10'(P_VEND)), .VT_RST(10'(P_VT))
    ) dut_i (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .lbclk_o(lbclk_o)
    );

    int n_chk = 0, n_err = 0, mism = 0, cyc = 0, de_cnt = 0;

    // shadow of the register file, kept from the requirements
    int s_hsw, s_hst, s_hend, s_ht0, s_ht1, s_vsw, s_vst, s_vend, s_vt, s_pol;
    int c_h, c_v, a_ht, a_vt;
    logic p_hs, p_vs, p_de, p_valid = 1'b0;

    task automatic shadow_reset();
        s_hsw = P_HSW; s_hst = P_HST; s_hend = P_HEND; s_ht0 = P_HT0; s_ht1 = P_HT1;
        s_vsw = P_VSW; s_vst = P_VST; s_vend = P_VEND; s_vt = P_VT; s_pol = 0;
    endtask

    task automatic shadow_write(input int a, input int d);
        case (a)
            'h10: s_hsw  = (s_hsw & 'h100) | d;
            'h11: s_hst  = (s_hst & 'h100) | d;
            'h12: s_hend = (s_hend & 'h700) | d;
            'h13: begin
                s_hsw  = (s_hsw & 'hFF) | ((d & 1) << 8);
                s_hst  = (s_hst & 'hFF) | (((d >> 1) & 1) << 8);
                s_hend = (s_hend & 'hFF) | (((d >> 4) & 7) << 8);
            end
            'h14: s_ht0 = (s_ht0 & 'h700) | d;
            'h15: s_ht1 = (s_ht1 & 'h700) | d;
            'h16: begin
                s_ht0 = (s_ht0 & 'hFF) | ((d & 7) << 8);
                s_ht1 = (s_ht1 & 'hFF) | (((d >> 4) & 7) << 8);
            end
            'h17: s_vsw = d;
            'h18: s_vst = d;
            'h19: s_vend = (s_vend & 'h300) | d;
            'h1A: s_vt   = (s_vt & 'h300) | d;
            'h1B: begin
                s_vend = (s_vend & 'hFF) | ((d & 3) << 8);
                s_vt   = (s_vt & 'hFF) | (((d >> 2) & 3) << 8);
            end
            'hF7: s_pol = d & 7;
            default: ;
        endcase
    endtask

    function automatic int shadow_read(input int a);
        case (a)
            'h10: return s_hsw & 'hFF;
            'h11: return s_hst & 'hFF;
            'h12: return s_hend & 'hFF;
            'h13: return ((s_hend >> 8) << 4) | ((s_hst >> 8) << 1) | (s_hsw >> 8);
            'h14: return s_ht0 & 'hFF;
            'h15: return s_ht1 & 'hFF;
            'h16: return ((s_ht1 >> 8) << 4) | (s_ht0 >> 8);
            'h17: return s_vsw;
            'h18: return s_vst;
            'h19: return s_vend & 'hFF;
            'h1A: return s_vt & 'hFF;
            'h1B: return ((s_vt >> 8) << 2) | (s_vend >> 8);
            'hF7: return s_pol;
            default: return 0;
        endcase
    endfunction

    // cycle model: predicts what the coming edge registers (R3-R7)
    always @(negedge clk) begin
        cyc++;
        if (de_o) de_cnt++;
        if (p_valid && (hsync_o !== p_hs || vsync_o !== p_vs || de_o !== p_de)) begin
            mism++;
            if (mism < 6)
                $display("model mismatch @%0d: hs=%b/%b vs=%b/%b de=%b/%b", cyc,
                         hsync_o, p_hs, vsync_o, p_vs, de_o, p_de);
        end
        if (rst) begin
            shadow_reset();
            c_h = 0; c_v = 0;
            a_ht = mode_sel ? s_ht1 : s_ht0;
            a_vt = s_vt;
            p_hs = 0; p_vs = 0; p_de = 0;
            p_valid = 1'b1;
        end else begin
            p_hs = (c_h < s_hsw);
            p_vs = (c_v < s_vsw);
            p_de = (c_h >= s_hst) && (c_h < s_hend) && (c_v >= s_vst) && (c_v < s_vend);
            if (c_h + 1 >= a_ht) begin
                c_h = 0;
                if (c_v + 1 >= a_vt) begin
                    c_v = 0;
                    a_ht = mode_sel ? s_ht1 : s_ht0;
                    a_vt = s_vt;
                end else c_v++;
            end else c_h++;
            if (reg_we) shadow_write(reg_addr, reg_wdata);
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int d);
        @(posedge clk); #1;
        reg_addr = a;
        #2 d = reg_rdata;
    endtask

    task automatic hperiod(output int n);
        int t0;
        @(posedge hsync_o); t0 = cyc;
        @(posedge hsync_o); n = cyc - t0;
    endtask

    task automatic model_clean(input string req, input int m0);
        check(mism == m0, req, mism - m0, 0);
    endtask

    // R1: reset state and reset register values
    task automatic t_reset();
        int d;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(!hsync_o && !vsync_o && !de_o, "R1 outputs low", {hsync_o, vsync_o, de_o}, 0);
        foreach (d_addrs[i]) begin
            rd(d_addrs[i], d);
            check(d == shadow_read(d_addrs[i]), "R1 reset value", d, shadow_read(d_addrs[i]));
        end
        @(negedge clk);
        check(lbclk_o == 3'b000, "R1 R8 polarity reset", lbclk_o, 0);
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    logic [7:0] d_addrs [13] = '{8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16,
                                 8'h17, 8'h18, 8'h19, 8'h1A, 8'h1B, 8'hF7};

    // R3 R4 R5 R6: default frame timing in mode 0
    task automatic t_frame();
        int n, t0, m0, d0;
        m0 = mism;
        @(posedge vsync_o);
        hperiod(n);
        check(n == P_HT0, "R3 line period", n, P_HT0);
        @(posedge hsync_o); t0 = cyc;
        @(negedge hsync_o);
        check(cyc - t0 == P_HSW, "R4 hsync width", cyc - t0, P_HSW);
        @(posedge vsync_o); t0 = cyc; d0 = de_cnt;
        @(negedge vsync_o);
        check(cyc - t0 == P_VSW * P_HT0, "R5 vsync width", cyc - t0, P_VSW * P_HT0);
        @(posedge vsync_o);
        check(cyc - t0 == P_VT * P_HT0, "R3 frame period", cyc - t0, P_VT * P_HT0);
        n = (P_HEND - P_HST) * (P_VEND - P_VST);
        check(de_cnt - d0 == n, "R6 active count", de_cnt - d0, n);
        model_clean("R3 R4 R5 R6 model", m0);
    endtask

    // R7: mode change mid-frame waits for the frame wrap
    task automatic t_mode_switch();
        int n, m0;
        m0 = mism;
        @(posedge vsync_o);
        repeat (3) @(posedge hsync_o);
        @(posedge clk); #1 mode_sel = 1'b1;
        hperiod(n);
        check(n == P_HT0, "R7 old total held", n, P_HT0);
        @(posedge vsync_o);
        hperiod(n);
        check(n == P_HT1, "R7 mode-1 total", n, P_HT1);
        model_clean("R7 mode model", m0);
    endtask

    // R7 R2: total register write mid-frame
    task automatic t_total_write();
        int n, d, m0;
        m0 = mism;
        @(posedge vsync_o);
        repeat (2) @(posedge hsync_o);
        wr(8'h15, 8'd50);
        rd(8'h15, d);
        check(d == 50, "R2 total readback", d, 50);
        hperiod(n);
        check(n == P_HT1, "R7 written total deferred", n, P_HT1);
        @(posedge vsync_o);
        hperiod(n);
        check(n == 50, "R7 written total applied", n, 50);
        model_clean("R7 write model", m0);
    endtask

    // R2 R9: bit packing and unused bits
    task automatic t_packing();
        int d, m0;
        m0 = mism;
        wr(8'h13, 8'hFF);
        rd(8'h13, d);
        check(d == 'h73, "R2 R9 horizontal high bits", d, 'h73);
        wr(8'h13, 8'h00);
        wr(8'h16, 8'h88);
        rd(8'h16, d);
        check(d == 'h00, "R9 total high unused", d, 0);
        wr(8'h16, 8'h10);
        rd(8'h16, d);
        check(d == 'h10, "R2 mode-1 high bits", d, 'h10);
        wr(8'h16, 8'h00);
        wr(8'h1B, 8'hF0);
        rd(8'h1B, d);
        check(d == 'h00, "R9 vertical high unused", d, 0);
        wr(8'h20, 8'hFF);
        rd(8'h20, d);
        check(d == 0, "R9 unmapped read", d, 0);
        rd(8'h12, d);
        check(d == P_HEND, "R9 unmapped write harmless", d, P_HEND);
        model_clean("R2 R9 model", m0);
    endtask

    // R6: empty window when start equals end
    task automatic t_empty_window();
        int d0, m0;
        m0 = mism;
        wr(8'h11, 8'd20);
        wr(8'h12, 8'd20);
        @(posedge vsync_o); d0 = de_cnt;
        @(posedge vsync_o);
        check(de_cnt == d0, "R6 empty window", de_cnt - d0, 0);
        wr(8'h11, 8'(P_HST));
        wr(8'h12, 8'(P_HEND));
        model_clean("R6 model", m0);
    endtask

    // R4: zero width gives no pulse
    task automatic t_zero_hsw();
        int t0, hi, m0;
        m0 = mism;
        wr(8'h10, 8'h00);
        t0 = cyc; hi = 0;
        while (cyc - t0 < 200) begin
            @(negedge clk);
            if (hsync_o) hi++;
        end
        check(hi == 0, "R4 zero width", hi, 0);
        wr(8'h10, 8'(P_HSW));
        model_clean("R4 model", m0);
    endtask

    // R8: per-output polarity
    task automatic t_polarity();
        int d;
        wr(8'hF7, 8'h05);
        rd(8'hF7, d);
        check(d == 'h05, "R8 readback", d, 5);
        @(negedge clk); #1;
        check(lbclk_o == 3'b101, "R8 clock low phase", lbclk_o, 5);
        @(posedge clk); #1;
        check(lbclk_o == 3'b010, "R8 clock high phase", lbclk_o, 2);
        wr(8'hF7, 8'hFF);
        rd(8'hF7, d);
        check(d == 'h07, "R8 R9 upper bits", d, 7);
    endtask

    initial begin : main
        shadow_reset();
        t_reset();
        t_frame();
        t_packing();
        t_empty_window();
        t_zero_hsw();
        t_mode_switch();
        t_total_write();
        t_polarity();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : watchdog
        #(8 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule